// File: doc/BRIEF.md
# Acknowledge-Started Bandwidth Request Timer

This block is one channel of a bandwidth-control timer that drives a request line to a DMA task. When the channel is switched on it raises its request and keeps it high until the task has been serviced for a set number of clocks. A serviced clock is one on which the acknowledge input is high. Once that quota has been met, the request drops and stays low until the next period begins.

The period does not run on its own. After each period begins, the period counter stays idle until the acknowledge input is first seen high. From that clock it counts a baseline number of clocks. The programmed length is therefore a minimum, and the real period grows by however long the first acknowledge is late. When the baseline count is reached, both counters clear, the request rises again, and the channel goes back to waiting for a first acknowledge. The channel has no interrupt output and does not report when a period ends before its quota has been met.

The caller works out the quota (the high-time reference) from a percentage of the period outside this block. Both the reference and the period length arrive as plain binary counts.

Top module: `acktmr_var_chan`

## Requirements
- R1: While `rst` is high, or on any clock edge where `enable` is sampled low, all state clears and `init_req` is low after that edge.
- R2: On the first clock edge where `enable` is sampled high after being off, `init_req` goes high. The quota count starts at zero.
- R3: After a period begins, the period counter does not advance until an edge samples `ack` high. With `ack` held low, no restart ever occurs, however long that lasts.
- R4: The quota counter adds one only on edges where `ack` is high. It saturates at `high_ref`. `init_req` goes low on the edge after the edge on which the count reaches `high_ref`, and stays low until the next period.
- R5: The edge that first samples `ack` high counts as period clock 1. On the edge `base_len` clocks after that edge, the period restarts: `init_req` goes high, and the quota count and the period count clear. A `base_len` of 0 behaves like 1.
- R6: An `ack` sampled on a restart edge, or on the first enabled edge, does not start the period and does not add to the quota.
- R7: With `high_ref` equal to 0, `init_req` is high for exactly one clock after each period start.
- R8: For the example setting of an 8-clock baseline and a 2-clock quota, the request falls on the edge after the second acknowledged clock. It rises again 8 clocks after the first acknowledged clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel on; low clears the channel |
| base_len | input | CW | Baseline period length in clocks |
| high_ref | input | CW | Number of acknowledged clocks that meet the quota |
| ack | input | 1 | Acknowledge from the DMA task; high means serviced this clock |
| init_req | output | 1 | Bandwidth request to the DMA task |

## Verification
A wrong period phase shows at the ports as a request that rises at the wrong moment. If the period started without an acknowledge, or counted one clock too many or too few, the rise moves. This shows on the very next restart, at most `base_len` clocks later. A wrong quota count shows as the request falling one or more clocks early or late. It can also show as the request never falling. This is visible on the edge right after the count should reach the reference. The sweep over small period lengths, quotas and acknowledge patterns compares the request on every clock, so a single-clock slip in either counter is caught within one period.

// File: rtl/acktmr_pkg.sv
package acktmr_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // Quota still open: fewer acknowledged clocks than the reference.
    function automatic logic quota_open(input int unsigned got, input int unsigned want);
        return got < want;
    endfunction

    // Period finished: the running count has met the baseline length.
    function automatic logic period_done(input int unsigned cnt, input int unsigned len);
        return cnt >= len;
    endfunction

endpackage

// File: rtl/acktmr_period_ctr.sv
module acktmr_period_ctr
    import acktmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          ack,
    input  logic [CW-1:0] base_len,
    output phase_e        phase,
    output logic          wrap
);

    logic [CW-1:0] cnt_q;
    phase_e        phase_q;

    assign phase = phase_q;
    assign wrap  = (phase_q == PH_RUN) && period_done(32'(cnt_q), 32'(base_len));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase_q <= PH_OFF;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_OFF: begin
                    phase_q <= PH_WAIT;
                    cnt_q   <= '0;
                end
                PH_WAIT: begin
                    if (ack) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= CW'(1);
                    end
                end
                PH_RUN: begin
                    if (wrap) begin
                        phase_q <= PH_WAIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    phase_q <= PH_OFF;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    a_r3_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (enable && phase_q == PH_WAIT && !ack) |=> (phase_q != PH_RUN));

    a_r5_run_steps: assert property (@(posedge clk) disable iff (rst)
        (enable && phase_q == PH_RUN && !wrap) |=> (phase_q == PH_RUN && cnt_q == $past(cnt_q) + CW'(1)));

    a_r6_wrap_waits: assert property (@(posedge clk) disable iff (rst)
        (enable && wrap) |=> (phase_q == PH_WAIT && cnt_q == '0));

endmodule

// File: rtl/acktmr_quota_ctr.sv
module acktmr_quota_ctr
    import acktmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          ack,
    input  logic [CW-1:0] high_ref,
    input  phase_e        phase,
    input  logic          wrap,
    output logic          req
);

    logic [CW-1:0] got_q;
    logic          req_q;
    logic          open_c;
    logic          restart_c;

    assign open_c    = quota_open(32'(got_q), 32'(high_ref));
    assign restart_c = (phase == PH_OFF) || wrap;
    assign req       = req_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            got_q <= '0;
            req_q <= 1'b0;
        end else if (restart_c) begin
            got_q <= '0;
            req_q <= 1'b1;
        end else begin
            req_q <= open_c;
            if (ack && open_c) begin
                got_q <= got_q + CW'(1);
            end
        end
    end

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (enable && !ack && !restart_c) |=> (got_q == $past(got_q)));

    a_r4_met_drops: assert property (@(posedge clk) disable iff (rst)
        (enable && !restart_c && !open_c) |=> !req_q);

    a_r6_restart_clear: assert property (@(posedge clk) disable iff (rst)
        (enable && restart_c) |=> (got_q == '0 && req_q));

endmodule

// File: rtl/acktmr_var_chan.sv
module acktmr_var_chan
    import acktmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [CW-1:0] base_len,
    input  logic [CW-1:0] high_ref,
    input  logic          ack,
    output logic          init_req
);

    phase_e phase_w;
    logic   wrap_w;

    acktmr_period_ctr #(.CW(CW)) period_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .ack      (ack),
        .base_len (base_len),
        .phase    (phase_w),
        .wrap     (wrap_w)
    );

    acktmr_quota_ctr #(.CW(CW)) quota_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .ack      (ack),
        .high_ref (high_ref),
        .phase    (phase_w),
        .wrap     (wrap_w),
        .req      (init_req)
    );

    a_r1_off_low: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !init_req);

    a_r2_arm_high: assert property (@(posedge clk) disable iff (rst)
        (enable && phase_w == PH_OFF) |=> init_req);

endmodule

// File: tb/acktmr_var_chan_tb.sv
`timescale 1ns/1ps
module acktmr_var_chan_tb_top;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic [CW-1:0] base_len;
    logic [CW-1:0] high_ref;
    logic          ack;
    logic          init_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Independent model state
    int m_ph, m_cnt, m_got;
    bit m_req;
    string m_tag;

    always #2 clk = ~clk;

    acktmr_var_chan #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .base_len(base_len),
        .high_ref(high_ref), .ack(ack), .init_req(init_req)
    );

    task automatic check(input bit exp, input string tag);
        n_checks++;
        if (init_req !== exp) begin
            n_fail++;
            $display("FAIL %s: init_req=%0b expected %0b at %0t", tag, init_req, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit en, input bit a, input int bl, input int hr);
        bit wr;
        bit nreq;
        if (r || !en) begin
            m_ph = 0; m_cnt = 0; m_got = 0; m_req = 0; m_tag = "R1";
            return;
        end
        wr = (m_ph == 2) && (m_cnt >= bl);
        if (m_ph == 0 || wr) begin
            m_got = 0; m_req = 1;
            m_tag = (m_ph == 0) ? "R2" : "R5";
        end else begin
            nreq = (m_got < hr);
            if (a && m_got < hr) m_got++;
            m_req = nreq;
            m_tag = "R4";
        end
        if (m_ph == 0) begin
            m_ph = 1; m_cnt = 0;
        end else if (m_ph == 1) begin
            if (a) begin m_ph = 2; m_cnt = 1; m_tag = {m_tag, "/R3"}; end
        end else begin
            if (wr) begin m_ph = 1; m_cnt = 0; end
            else m_cnt++;
        end
    endtask

    // Drive inputs at the falling edge, step model, wait to next falling edge.
    task automatic drive(input bit en, input bit a);
        enable = en; ack = a;
        model_step(rst, en, a, int'(base_len), int'(high_ref));
        @(negedge clk);
    endtask

    function automatic bit pat_ack(input int p, input int i);
        case (p)
            0: return 1'b1;
            1: return (i % 3) == 0;
            2: return ((i * 7) >> 1) & 1;
            default: return (i >= 10) && (i % 2 == 1);
        endcase
    endfunction

    initial begin
        rst = 1'b1; enable = 1'b0; ack = 1'b0; base_len = 8'd8; high_ref = 8'd2;
        model_step(1, 0, 0, 8, 2);
        @(negedge clk); @(negedge clk);
        check(1'b0, "R1 reset");
        rst = 1'b0;
        drive(0, 1);
        check(1'b0, "R1 disabled");

        // Directed example: 8-clock baseline, 2-clock quota
        drive(1, 1);                 check(1'b1, "R2 arm / R6 ack on first edge ignored");
        for (int k = 0; k < 5; k++) begin
            drive(1, 0);             check(1'b1, "R3 waiting without ack");
        end
        drive(1, 1);                 check(1'b1, "R8 first ack");
        drive(1, 0);                 check(1'b1, "R8 cnt2");
        drive(1, 0);                 check(1'b1, "R8 cnt3");
        drive(1, 1);                 check(1'b1, "R8 second ack");
        drive(1, 0);                 check(1'b0, "R4 quota met drops request");
        drive(1, 0);                 check(1'b0, "R4 stays low");
        drive(1, 0);                 check(1'b0, "R4 stays low");
        drive(1, 0);                 check(1'b0, "R8 last period clock");
        drive(1, 1);                 check(1'b1, "R5 restart after 8 clocks");
        drive(1, 1);                 check(1'b1, "R6 one ack counted");
        drive(1, 0);                 check(1'b1, "R6 wrap ack not counted");
        drive(1, 0);                 check(1'b1, "R6 still open");
        drive(0, 1);                 check(1'b0, "R1 disable clears");
        high_ref = 8'd0;
        drive(1, 0);                 check(1'b1, "R7 zero quota arm");
        drive(1, 1);                 check(1'b0, "R7 zero quota one clock");

        // Sweep against the arithmetic model
        for (int bl = 0; bl <= 6; bl++) begin
            for (int hr = 0; hr <= 4; hr++) begin
                for (int p = 0; p < 4; p++) begin
                    base_len = CW'(bl); high_ref = CW'(hr);
                    drive(0, 0);
                    check(m_req, "R1 sweep disable");
                    for (int i = 0; i < 40; i++) begin
                        drive(1, pat_ack(p, i));
                        check(m_req, m_tag);
                    end
                end
            end
        end

        // Synchronous reset in mid-period
        base_len = 8'd5; high_ref = 8'd3;
        drive(1, 1); drive(1, 1);
        rst = 1'b1;
        drive(1, 1);                 check(1'b0, "R1 reset mid-period");
        rst = 1'b0;
        drive(1, 0);                 check(1'b1, "R2 arm after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule